// File: doc/BRIEF.md
# Host Memory Range Decoder

This block sorts each host physical memory address into an address region and sends it to one of three targets: the on-chip graphics engine, main DRAM, or the downstream bridge to the I/O hub. The decode bounds come in on input ports: the top of usable low memory, the top of all memory, the base and limit of a remapped reclaim window above 4 GB, and two bits that steer the legacy video window. Nothing here programs those bounds. Another block holds them.

A request is an address presented with a valid/ready handshake. The decode result is registered. It appears one cycle after the address is accepted, as a one-hot target select plus a 3-bit region code, and it stays there until the consumer takes it. The legacy video window is always settled in favour of on-chip graphics first. Only after that is it considered for the bridge. Any address that falls in no known region goes to the bridge as a subtractive access.

Top module: `hmem_route_top`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An address accepted on a clock edge (`req_valid` and `req_ready` both high) produces `rsp_valid`=1 with its decode on the next edge. While `rsp_valid`=1 and `rsp_ready`=0, the response and its address hold steady and `req_ready` is 0.
- R3: `rsp_tgt` is one-hot whenever `rsp_valid` is 1: bit 0 selects graphics, bit 1 selects DRAM, bit 2 selects the bridge.
- R4: The legacy window is split into three parts, each with its own region code: 000A_0000h–000A_FFFFh gives code 1, 000B_0000h–000B_7FFFh gives code 2, and 000B_8000h–000B_FFFFh gives code 3.
- R5: With `gfx_claim`=1, every address in 000A_0000h–000B_FFFFh targets graphics, whatever `vga_fwd` is set to.
- R6: With `gfx_claim`=0 and `vga_fwd`=1, legacy window addresses target the bridge and keep their legacy region code.
- R7: With `gfx_claim`=0 and `vga_fwd`=0, legacy window addresses target DRAM and keep their legacy region code.
- R8: Addresses from 0100_0000h up to but not including `low_top` target DRAM with code 4.
- R9: Addresses from 4 GB up to but not including `mem_top` target DRAM with code 5, unless R10 applies.
- R10: Addresses from `rcl_base` through `rcl_limit`, with both ends included, target DRAM with code 6 and take precedence over code 5. The window is active only when `rcl_base` is at least 4 GB and no greater than `rcl_limit`.
- R11: Every other address targets the bridge with code 0 (subtractive).
- R12: A new address can be accepted on the same edge that the held response is consumed, so back-to-back requests sustain one decode per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address valid |
| req_ready | output | 1 | Decoder can accept an address |
| req_addr | input | ADDR_W | Host physical address |
| low_top | input | ADDR_W | Exclusive top of low usable memory |
| mem_top | input | ADDR_W | Exclusive top of memory above 4 GB |
| rcl_base | input | ADDR_W | First address of the reclaim window |
| rcl_limit | input | ADDR_W | Last address of the reclaim window |
| gfx_claim | input | 1 | On-chip graphics claims the legacy video window |
| vga_fwd | input | 1 | Forward the unclaimed legacy window to the bridge |
| rsp_valid | output | 1 | Decode result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | ADDR_W | Address the result belongs to |
| rsp_tgt | output | 3 | One-hot target: bit0 graphics, bit1 DRAM, bit2 bridge |
| rsp_region | output | 3 | Region code, 0 to 6 |

## Verification
Two things can happen in the same cycle. One is the graphics claim and the bridge forward both asserting a legacy address. The other is the reclaim window and high memory both covering one address. The bench sets `gfx_claim` and `vga_fwd` together, and judges the result by graphics winning across all three legacy parts. It also places the reclaim window inside high memory and probes both of its edges, plus the addresses just outside them, expecting code 6 inside and code 5 outside. A separate stall case releases a held response on the same edge a new address arrives, and checks that both decodes come out in order.

// File: rtl/hmr_pkg.sv
// Package: shared region codes, target bit positions and legacy window bounds
// for the host memory range decoder. Assumes addresses wider than 32 bits.
package hmr_pkg;

    typedef enum logic [2:0] {
        RG_SUBTR   = 3'd0,
        RG_VGA_A   = 3'd1,
        RG_MDA     = 3'd2,
        RG_VGA_B   = 3'd3,
        RG_MAIN    = 3'd4,
        RG_HIGH    = 3'd5,
        RG_RECLAIM = 3'd6
    } region_e;

    localparam int TGT_W      = 3;
    localparam int TGT_GFX    = 0;
    localparam int TGT_DRAM   = 1;
    localparam int TGT_BRIDGE = 2;

    localparam int LEG_WINS   = 3;

    localparam logic [31:0] LEG_A_LO   = 32'h000A_0000;
    localparam logic [31:0] LEG_A_HI   = 32'h000A_FFFF;
    localparam logic [31:0] LEG_MDA_LO = 32'h000B_0000;
    localparam logic [31:0] LEG_MDA_HI = 32'h000B_7FFF;
    localparam logic [31:0] LEG_B_LO   = 32'h000B_8000;
    localparam logic [31:0] LEG_B_HI   = 32'h000B_FFFF;
    localparam logic [31:0] MAIN_BASE  = 32'h0100_0000;

endpackage

// File: rtl/hmr_legacy_dec.sv
// Module: hmr_legacy_dec
// Finds whether an address lies in one of the three legacy video windows and
// reports which one. Pure combinational; the windows do not overlap.
module hmr_legacy_dec
    import hmr_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              leg_hit,
    output region_e           leg_code
);

    logic [LEG_WINS-1:0] win_hit;

    // One range comparator per legacy window.
    for (genvar w = 0; w < LEG_WINS; w++) begin : g_win
        localparam logic [31:0] LO32 = (w == 0) ? LEG_A_LO :
                                       (w == 1) ? LEG_MDA_LO : LEG_B_LO;
        localparam logic [31:0] HI32 = (w == 0) ? LEG_A_HI :
                                       (w == 1) ? LEG_MDA_HI : LEG_B_HI;
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(LO32);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(HI32);
        assign win_hit[w] = (addr >= LO) && (addr <= HI);
    end

    // Turn the window hit vector into a region code.
    always_comb begin
        leg_hit  = |win_hit;
        leg_code = RG_SUBTR;
        if (win_hit[0])      leg_code = RG_VGA_A;
        else if (win_hit[1]) leg_code = RG_MDA;
        else if (win_hit[2]) leg_code = RG_VGA_B;
    end

endmodule

// File: rtl/hmr_dram_dec.sv
// Module: hmr_dram_dec
// Compares an address against the programmable DRAM ranges: main memory below
// low_top, high memory between 4 GB and mem_top, and the reclaim window.
// LIMIT_INCL selects whether rcl_limit is the last address (1) or one past it (0).
module hmr_dram_dec
    import hmr_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter bit LIMIT_INCL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] low_top,
    input  logic [ADDR_W-1:0] mem_top,
    input  logic [ADDR_W-1:0] rcl_base,
    input  logic [ADDR_W-1:0] rcl_limit,
    output logic              main_hit,
    output logic              high_hit,
    output logic              rcl_hit
);

    localparam logic [ADDR_W-1:0] FOUR_GB  = ADDR_W'(1) << 32;
    localparam logic [ADDR_W-1:0] MAIN_LO  = ADDR_W'(MAIN_BASE);

    logic rcl_enabled;
    logic rcl_below_top;

    // Main and high memory use exclusive upper bounds.
    always_comb begin
        main_hit = (addr >= MAIN_LO) && (addr < low_top);
        high_hit = (addr >= FOUR_GB) && (addr < mem_top);
    end

    // The limit compare style is chosen by parameter.
    if (LIMIT_INCL) begin : g_incl
        assign rcl_below_top = (addr <= rcl_limit);
        assign rcl_enabled   = (rcl_base >= FOUR_GB) && (rcl_base <= rcl_limit);
    end else begin : g_excl
        assign rcl_below_top = (addr < rcl_limit);
        assign rcl_enabled   = (rcl_base >= FOUR_GB) && (rcl_base < rcl_limit);
    end

    // The reclaim window counts only when it is enabled and well formed.
    always_comb begin
        rcl_hit = rcl_enabled && (addr >= rcl_base) && rcl_below_top;
    end

endmodule

// File: rtl/hmr_resolve.sv
// Module: hmr_resolve
// Applies fixed precedence to the raw range hits: legacy window (graphics,
// then bridge forward, then DRAM), main, reclaim, high, else subtractive.
// Produces a one-hot target and a region code.
module hmr_resolve
    import hmr_pkg::*;
(
    input  logic             leg_hit,
    input  region_e          leg_code,
    input  logic             main_hit,
    input  logic             high_hit,
    input  logic             rcl_hit,
    input  logic             gfx_claim,
    input  logic             vga_fwd,
    output logic [TGT_W-1:0] tgt,
    output region_e          region
);

    int unsigned sel;

    // Priority chain that picks a target index and region.
    always_comb begin
        sel    = TGT_BRIDGE;
        region = RG_SUBTR;
        if (leg_hit) begin
            region = leg_code;
            if (gfx_claim)    sel = TGT_GFX;
            else if (vga_fwd) sel = TGT_BRIDGE;
            else              sel = TGT_DRAM;
        end else if (main_hit) begin
            region = RG_MAIN;
            sel    = TGT_DRAM;
        end else if (rcl_hit) begin
            region = RG_RECLAIM;
            sel    = TGT_DRAM;
        end else if (high_hit) begin
            region = RG_HIGH;
            sel    = TGT_DRAM;
        end
    end

    // Expand the selected index into a one-hot select.
    for (genvar t = 0; t < TGT_W; t++) begin : g_onehot
        assign tgt[t] = (sel == t);
    end

endmodule

// File: rtl/hmr_out_stage.sv
// Module: hmr_out_stage
// Single register slice holding the decode result under valid/ready flow
// control. A new result may load on the same edge the old one is consumed.
module hmr_out_stage
    import hmr_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TGT_W-1:0]  in_tgt,
    input  region_e           in_region,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [TGT_W-1:0]  rsp_tgt,
    output region_e           rsp_region
);

    logic accept;

    // Ready when empty or when the held result leaves this cycle.
    always_comb begin
        req_ready = rst_n && (!rsp_valid || rsp_ready);
        accept    = req_valid && req_ready;
    end

    // Load a new result on accept; drop valid when the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_tgt    <= '0;
            rsp_region <= RG_SUBTR;
        end else if (accept) begin
            rsp_valid  <= 1'b1;
            rsp_addr   <= in_addr;
            rsp_tgt    <= in_tgt;
            rsp_region <= in_region;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rsp_valid); // R1

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                       && $stable(rsp_tgt) && $stable(rsp_region))); // R2

    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R12

endmodule

// File: rtl/hmem_route_top.sv
// Module: hmem_route_top
// Host memory range decoder top: legacy and DRAM range compares feed a fixed
// precedence resolver whose result is registered behind a valid/ready slice.
// Bounds and steering bits are sampled on the edge that accepts an address.
module hmem_route_top
    import hmr_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter bit LIMIT_INCL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] low_top,
    input  logic [ADDR_W-1:0] mem_top,
    input  logic [ADDR_W-1:0] rcl_base,
    input  logic [ADDR_W-1:0] rcl_limit,
    input  logic              gfx_claim,
    input  logic              vga_fwd,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_tgt,
    output logic [2:0]        rsp_region
);

    logic             leg_hit;
    region_e          leg_code;
    logic             main_hit;
    logic             high_hit;
    logic             rcl_hit;
    logic [TGT_W-1:0] dec_tgt;
    region_e          dec_region;
    region_e          held_region;

    hmr_legacy_dec #(.ADDR_W(ADDR_W)) u_legacy (
        .addr     (req_addr),
        .leg_hit  (leg_hit),
        .leg_code (leg_code)
    );

    hmr_dram_dec #(.ADDR_W(ADDR_W), .LIMIT_INCL(LIMIT_INCL)) u_dram (
        .addr      (req_addr),
        .low_top   (low_top),
        .mem_top   (mem_top),
        .rcl_base  (rcl_base),
        .rcl_limit (rcl_limit),
        .main_hit  (main_hit),
        .high_hit  (high_hit),
        .rcl_hit   (rcl_hit)
    );

    hmr_resolve u_resolve (
        .leg_hit   (leg_hit),
        .leg_code  (leg_code),
        .main_hit  (main_hit),
        .high_hit  (high_hit),
        .rcl_hit   (rcl_hit),
        .gfx_claim (gfx_claim),
        .vga_fwd   (vga_fwd),
        .tgt       (dec_tgt),
        .region    (dec_region)
    );

    hmr_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .in_addr    (req_addr),
        .in_tgt     (dec_tgt),
        .in_region  (dec_region),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_addr   (rsp_addr),
        .rsp_tgt    (rsp_tgt),
        .rsp_region (held_region)
    );

    // Present the region as a plain 3-bit code at the boundary.
    always_comb rsp_region = held_region;

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_tgt) == 1)); // R3

    AST_GFX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && gfx_claim
         && req_addr >= ADDR_W'(32'h000A_0000) && req_addr <= ADDR_W'(32'h000B_FFFF))
        |=> (rsp_valid && rsp_tgt == 3'b001)); // R5

    AST_SUBTR_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == 3'd0) |-> (rsp_tgt == 3'b100)); // R11

    AST_DRAM_REGIONS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region >= 3'd4) |-> (rsp_tgt == 3'b010)); // R8

endmodule

// File: tb/hmem_route_top_test.sv
// Directed bench for hmem_route_top: one task per scenario, each checking its
// own results. Inputs change on the falling edge; outputs are read there too.
module hmem_route_top_test;

    localparam int    AW       = 36;
    localparam time   CLK_PER  = 10;
    localparam logic [2:0] T_GFX = 3'b001;
    localparam logic [2:0] T_DRM = 3'b010;
    localparam logic [2:0] T_BRG = 3'b100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] low_top   = 36'h0_8000_0000;
    logic [AW-1:0] mem_top   = 36'h2_0000_0000;
    logic [AW-1:0] rcl_base  = 36'h1_4000_0000;
    logic [AW-1:0] rcl_limit = 36'h1_7FFF_FFFF;
    logic          gfx_claim = 1'b1;
    logic          vga_fwd   = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [AW-1:0] rsp_addr;
    logic [2:0]    rsp_tgt;
    logic [2:0]    rsp_region;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    hmem_route_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .low_top(low_top), .mem_top(mem_top),
        .rcl_base(rcl_base), .rcl_limit(rcl_limit), .gfx_claim(gfx_claim),
        .vga_fwd(vga_fwd), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_tgt(rsp_tgt), .rsp_region(rsp_region)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Compare the currently presented response with expected values.
    task automatic check_rsp(input string tag, input logic [AW-1:0] a,
                             input logic [2:0] et, input logic [2:0] er);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_addr !== a || rsp_tgt !== et || rsp_region !== er) begin
            fails++;
            $display("FAIL %s: addr %h got v=%0b a=%h tgt=%b reg=%0d expected tgt=%b reg=%0d",
                     tag, a, rsp_valid, rsp_addr, rsp_tgt, rsp_region, et, er);
        end
    endtask

    // Issue one address, then check the result a cycle later.
    task automatic probe(input string tag, input logic [AW-1:0] a,
                         input logic [2:0] et, input logic [2:0] er);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, a, et, er);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
        check_bit("R1 req_ready after reset", req_ready, 1'b1);
    endtask

    task automatic t_legacy_gfx;
        gfx_claim = 1'b1; vga_fwd = 1'b1;
        probe("R4 R5 vga A low",  36'h0_000A_0000, T_GFX, 3'd1);
        probe("R4 R5 vga A high", 36'h0_000A_FFFF, T_GFX, 3'd1);
        probe("R4 R5 mda low",    36'h0_000B_0000, T_GFX, 3'd2);
        probe("R4 R5 mda high",   36'h0_000B_7FFF, T_GFX, 3'd2);
        probe("R4 R5 vga B low",  36'h0_000B_8000, T_GFX, 3'd3);
        probe("R4 R5 vga B high", 36'h0_000B_FFFF, T_GFX, 3'd3);
    endtask

    task automatic t_legacy_steer;
        gfx_claim = 1'b0; vga_fwd = 1'b1;
        probe("R6 mda to bridge",  36'h0_000B_0000, T_BRG, 3'd2);
        probe("R6 vga B to bridge", 36'h0_000B_C000, T_BRG, 3'd3);
        vga_fwd = 1'b0;
        probe("R7 vga A to dram",  36'h0_000A_0000, T_DRM, 3'd1);
        probe("R7 mda to dram",    36'h0_000B_7FFF, T_DRM, 3'd2);
        gfx_claim = 1'b1;
    endtask

    task automatic t_low_memory;
        probe("R11 below legacy",  36'h0_0009_FFFF, T_BRG, 3'd0);
        probe("R11 above legacy",  36'h0_000C_0000, T_BRG, 3'd0);
        probe("R11 below main",    36'h0_00FF_FFFF, T_BRG, 3'd0);
        probe("R8 main base",      36'h0_0100_0000, T_DRM, 3'd4);
        probe("R8 main last",      36'h0_7FFF_FFFF, T_DRM, 3'd4);
        probe("R8 R11 at low_top", 36'h0_8000_0000, T_BRG, 3'd0);
        probe("R11 below 4GB",     36'h0_FFFF_FFFF, T_BRG, 3'd0);
    endtask

    task automatic t_high_reclaim;
        probe("R9 4GB",             36'h1_0000_0000, T_DRM, 3'd5);
        probe("R9 below reclaim",   36'h1_3FFF_FFFF, T_DRM, 3'd5);
        probe("R10 reclaim base",   36'h1_4000_0000, T_DRM, 3'd6);
        probe("R10 reclaim limit",  36'h1_7FFF_FFFF, T_DRM, 3'd6);
        probe("R9 past reclaim",    36'h1_8000_0000, T_DRM, 3'd5);
        probe("R9 last high",       36'h1_FFFF_FFFF, T_DRM, 3'd5);
        probe("R9 R11 at mem_top",  36'h2_0000_0000, T_BRG, 3'd0);
        rcl_base = 36'h3_0000_0000; rcl_limit = 36'h3_0FFF_FFFF;
        probe("R10 reclaim above top", 36'h3_0000_0000, T_DRM, 3'd6);
        rcl_base = 36'h0_C000_0000; rcl_limit = 36'h0_CFFF_FFFF;
        probe("R10 base below 4GB off", 36'h0_C000_0000, T_BRG, 3'd0);
        rcl_base = 36'h1_6000_0000; rcl_limit = 36'h1_5000_0000;
        probe("R10 base over limit off", 36'h1_6000_0000, T_DRM, 3'd5);
        rcl_base = 36'h1_4000_0000; rcl_limit = 36'h1_7FFF_FFFF;
    endtask

    task automatic t_stall;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 36'h0_0200_0000;
        @(negedge clk);
        req_addr = 36'h1_0000_1000;
        check_rsp("R2 first result", 36'h0_0200_0000, T_DRM, 3'd4);
        check_bit("R2 not ready while held", req_ready, 1'b0);
        repeat (2) @(negedge clk);
        check_rsp("R2 held during stall", 36'h0_0200_0000, T_DRM, 3'd4);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R12 accept on release", 36'h1_0000_1000, T_DRM, 3'd5);
        @(negedge clk);
        check_bit("R2 drained", rsp_valid, 1'b0);
    endtask

    task automatic t_stream;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 36'h0_000A_1000;
        @(negedge clk);
        check_bit("R12 ready in stream", req_ready, 1'b1);
        req_addr = 36'h1_5000_0000;
        check_rsp("R12 stream 1", 36'h0_000A_1000, T_GFX, 3'd1);
        @(negedge clk);
        req_addr = 36'h0_000C_8000;
        check_rsp("R12 stream 2", 36'h1_5000_0000, T_DRM, 3'd6);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R12 stream 3", 36'h0_000C_8000, T_BRG, 3'd0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_legacy_gfx();
        t_legacy_steer();
        t_low_memory();
        t_high_reclaim();
        t_stall();
        t_stream();
        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_run();
        end
    end

endmodule